// File: doc/BRIEF.md
# Low-Power Mode Wake Controller

This block tracks whether a processor is running, waiting, or stopped. It gates the processor clock in the two low-power states. It decides which interrupt requests may bring the processor back. It also owns the small clock-configuration register that says which oscillator drives the system clock and by how much it is divided. Software asks for wait or stop with a one-cycle request. In wait mode, a setting chooses whether peripheral clocks keep running. Each interrupt source then wakes the processor only if three things hold: its priority beats the processor's current level, interrupts are globally enabled, and the source's class allows it in the present low-power mode. Per-source qualifier inputs say whether a peripheral is clocked from outside or is counting external events.

When an interrupt wakes the processor, the block pulses an acknowledge together with the index of the winning source, so the interrupt can be serviced after resume. On stop entry from the main clock, the block forces the divide-by-8 select so that the processor restarts slowly. On stop entry from the subclock, and on any wait entry, the configuration is left as it was, so the processor resumes with the clock it had.

Top module: `pmw_wake_ctrl`

## Requirements
- R1: A high `rst` sampled at a clock edge puts the block in the run state, whatever state it was in. After that edge `pwr_state`=00, `clk_gate_en`=1, `periph_clk_en`=1, `wake_ack`=0, `cfg_sub`=0, `cfg_div8`=1 and `cfg_ratio`=00.
- R2: In the run state, `stop_req` enters stop (`pwr_state`=10) at the next edge, and `wait_req` enters wait (`pwr_state`=01). When both are high, stop wins. `clk_gate_en` is 0 in wait and in stop. `periph_clk_en` is 1 in wait only when `periph_stop_wait` was 0 at entry.
- R3: Source i is eligible only when all of these hold: `irq_req[i]`=1, `irq_en`=1, and its 3-bit priority `irq_prio[3i+2:3i]` is strictly greater than `cpu_ipl`. A priority of 0 never wakes the block.
- R4: In wait or stop, an eligible source returns the block to run at the next edge. In that same cycle, `wake_ack` is 1 for exactly one cycle and `wake_id` holds the source index.
- R5: When several sources are eligible, the highest priority wins. Equal priorities go to the lowest index.
- R6: Sources 0 and 1 (DMA channels) never wake the block in any mode.
- R7: Sources 6 and above (key input, external pins, non-maskable pin) wake the block in every low-power mode, regardless of `irq_qual`.
- R8: Source 2 (analog-to-digital) wakes the block only in wait with peripheral clocks running, and only when `irq_qual[2]`=1.
- R9: Sources 3 to 5 (serial and timer) wake the block unconditionally in wait with peripheral clocks running. In stop, or in wait with peripheral clocks stopped, they wake it only when their `irq_qual` bit is 1.
- R10: Wait entry and wait exit leave `cfg_sub`, `cfg_div8` and `cfg_ratio` unchanged. The configuration is held constant in every cycle spent in wait or stop.
- R11: Stop entry with `cfg_sub`=0 sets `cfg_div8` to 1 and keeps `cfg_ratio` and `cfg_sub`. Stop entry with `cfg_sub`=1 changes no configuration bit.
- R12: A wait request with `periph_stop_wait`=1 while `cfg_sub`=1 (low-speed or low-power operation) is refused. The block stays in run, `wake_ack` stays 0, and the configuration is unchanged.
- R13: A stop or wait request made while a source is already eligible for the requested mode keeps the block in run. In that case `wake_ack` rises at the next edge with that source's `wake_id`, and `cfg_div8` is not forced.
- R14: `cfg_we` loads `cfg_wr_sub`, `cfg_wr_div8` and `cfg_wr_ratio` only in a run-state cycle with no mode request. It is ignored in wait, in stop, and in cycles carrying `wait_req` or `stop_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wait_req | input | 1 | One-cycle request to enter wait |
| stop_req | input | 1 | One-cycle request to enter stop |
| periph_stop_wait | input | 1 | Stop peripheral clocks during the wait being entered |
| cfg_we | input | 1 | Write strobe for the clock configuration |
| cfg_wr_sub | input | 1 | Write value: subclock selected |
| cfg_wr_div8 | input | 1 | Write value: divide-by-8 select |
| cfg_wr_ratio | input | 2 | Write value: divider ratio bits |
| irq_req | input | NUM_SRC | Interrupt request per source |
| irq_prio | input | NUM_SRC*PRIO_W | Priority per source, source i at bits [PRIO_W*i +: PRIO_W] |
| irq_qual | input | NUM_SRC | Per-source qualifier: external clock, event counting, or one-shot conversion |
| cpu_ipl | input | PRIO_W | Processor interrupt priority level |
| irq_en | input | 1 | Global interrupt enable |
| pwr_state | output | 2 | 00 run, 01 wait, 10 stop |
| clk_gate_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| cfg_sub | output | 1 | Subclock drives the system clock |
| cfg_div8 | output | 1 | Divide-by-8 select |
| cfg_ratio | output | 2 | Divider ratio bits |
| wake_ack | output | 1 | One-cycle wake acknowledge |
| wake_id | output | IDW | Index of the acknowledged source |

## Verification
The assertions assume that `rst` is held through at least one edge before any check applies. They also assume that the mode requests last a single cycle and that `irq_en` and the priorities are settled at the edge where a wake is taken. The stimulus drives every input on the falling edge and keeps each request high for exactly one cycle. Between scenarios it withdraws all interrupt requests before it issues the next mode request, so every wake comes from the source under test. The one exception is the deliberate pending-at-entry case.

// File: rtl/pmw_pkg.sv
package pmw_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'b00,
        PM_WAIT = 2'b01,
        PM_STOP = 2'b10
    } pm_state_e;

    typedef enum logic [1:0] {
        WM_WAIT_CLK   = 2'b00,
        WM_WAIT_NOCLK = 2'b01,
        WM_STOP       = 2'b10
    } wake_mode_e;

    typedef enum logic [1:0] {
        SC_NEVER  = 2'b00,
        SC_ALWAYS = 2'b01,
        SC_ADC    = 2'b10,
        SC_QUAL   = 2'b11
    } src_class_e;

    typedef struct packed {
        logic       sub_sel;
        logic       div8;
        logic [1:0] ratio;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{sub_sel: 1'b0, div8: 1'b1, ratio: 2'b00};

    // Fixed source map: DMA, converter, serial/timer, then pin-type sources.
    function automatic src_class_e src_class(input int idx);
        if (idx < 2)      return SC_NEVER;
        else if (idx == 2) return SC_ADC;
        else if (idx < 6) return SC_QUAL;
        else              return SC_ALWAYS;
    endfunction

    function automatic logic class_allows(input src_class_e c, input wake_mode_e m,
                                          input logic q);
        case (c)
            SC_ALWAYS: return 1'b1;
            SC_ADC:    return (m == WM_WAIT_CLK) && q;
            SC_QUAL:   return (m == WM_WAIT_CLK) || q;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pmw_wake_filter.sv
module pmw_wake_filter
    import pmw_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3
) (
    input  logic [NUM_SRC-1:0]        irq_req,
    input  logic [NUM_SRC*PRIO_W-1:0] irq_prio,
    input  logic [NUM_SRC-1:0]        irq_qual,
    input  logic [PRIO_W-1:0]         cpu_ipl,
    input  logic                      irq_en,
    input  wake_mode_e                mode,
    output logic [NUM_SRC-1:0]        elig
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam src_class_e CLS = src_class(i);
        logic [PRIO_W-1:0] prio_i;
        assign prio_i  = irq_prio[i*PRIO_W +: PRIO_W];
        assign elig[i] = irq_req[i] && irq_en && (prio_i > cpu_ipl)
                         && class_allows(CLS, mode, irq_qual[i]);
    end

endmodule

// File: rtl/pmw_prio_pick.sv
module pmw_prio_pick #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int IDW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]        elig,
    input  logic [NUM_SRC*PRIO_W-1:0] irq_prio,
    output logic                      win_valid,
    output logic [IDW-1:0]            win_id
);

    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        best_prio = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!win_valid || irq_prio[i*PRIO_W +: PRIO_W] > best_prio)) begin
                win_valid = 1'b1;
                win_id    = IDW'(i);
                best_prio = irq_prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/pmw_clk_cfg.sv
module pmw_clk_cfg
    import pmw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  clk_cfg_t wr_data,
    input  logic     stop_enter,
    output clk_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (stop_enter) begin
            if (!cfg_q.sub_sel) cfg_q.div8 <= 1'b1;
        end else if (wr_en) begin
            cfg_q <= wr_data;
        end
    end

    // R11
    sub_stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_enter && cfg_q.sub_sel) |=> $stable(cfg_q));

endmodule

// File: rtl/pmw_wake_ctrl.sv
module pmw_wake_ctrl
    import pmw_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int IDW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wait_req,
    input  logic                      stop_req,
    input  logic                      periph_stop_wait,
    input  logic                      cfg_we,
    input  logic                      cfg_wr_sub,
    input  logic                      cfg_wr_div8,
    input  logic [1:0]                cfg_wr_ratio,
    input  logic [NUM_SRC-1:0]        irq_req,
    input  logic [NUM_SRC*PRIO_W-1:0] irq_prio,
    input  logic [NUM_SRC-1:0]        irq_qual,
    input  logic [PRIO_W-1:0]         cpu_ipl,
    input  logic                      irq_en,
    output logic [1:0]                pwr_state,
    output logic                      clk_gate_en,
    output logic                      periph_clk_en,
    output logic                      cfg_sub,
    output logic                      cfg_div8,
    output logic [1:0]                cfg_ratio,
    output logic                      wake_ack,
    output logic [IDW-1:0]            wake_id
);

    pm_state_e          state_q, state_d;
    wake_mode_e         mode_q, mode_c;
    clk_cfg_t           cfg_q, cfg_wdata;
    logic [NUM_SRC-1:0] elig;
    logic               win_valid;
    logic [IDW-1:0]     win_id;
    logic               in_run, refused, req_ok, stop_enter, take_wake, cfg_wr_ok;
    logic               ack_q;
    logic [IDW-1:0]     id_q;

    assign in_run  = (state_q == PM_RUN);
    assign refused = wait_req && !stop_req && periph_stop_wait && cfg_q.sub_sel;
    assign req_ok  = in_run && (stop_req || (wait_req && !refused));

    always_comb begin
        if (in_run)
            mode_c = stop_req ? WM_STOP : (periph_stop_wait ? WM_WAIT_NOCLK : WM_WAIT_CLK);
        else
            mode_c = mode_q;
    end

    pmw_wake_filter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_filter (
        .irq_req (irq_req),
        .irq_prio(irq_prio),
        .irq_qual(irq_qual),
        .cpu_ipl (cpu_ipl),
        .irq_en  (irq_en),
        .mode    (mode_c),
        .elig    (elig)
    );

    pmw_prio_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick (
        .elig     (elig),
        .irq_prio (irq_prio),
        .win_valid(win_valid),
        .win_id   (win_id)
    );

    assign take_wake  = win_valid && (req_ok || !in_run);
    assign stop_enter = req_ok && stop_req && !win_valid;
    assign cfg_wr_ok  = cfg_we && in_run && !wait_req && !stop_req;
    assign cfg_wdata  = '{sub_sel: cfg_wr_sub, div8: cfg_wr_div8, ratio: cfg_wr_ratio};

    pmw_clk_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr_ok),
        .wr_data   (cfg_wdata),
        .stop_enter(stop_enter),
        .cfg_q     (cfg_q)
    );

    always_comb begin
        state_d = state_q;
        if (take_wake)
            state_d = PM_RUN;
        else if (req_ok)
            state_d = stop_req ? PM_STOP : PM_WAIT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PM_RUN;
            mode_q  <= WM_WAIT_CLK;
            ack_q   <= 1'b0;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            ack_q   <= take_wake;
            if (req_ok && !win_valid) mode_q <= mode_c;
            if (take_wake)            id_q   <= win_id;
        end
    end

    assign pwr_state     = state_q;
    assign clk_gate_en   = in_run;
    assign periph_clk_en = in_run || (state_q == PM_WAIT && mode_q == WM_WAIT_CLK);
    assign cfg_sub       = cfg_q.sub_sel;
    assign cfg_div8      = cfg_q.div8;
    assign cfg_ratio     = cfg_q.ratio;
    assign wake_ack      = ack_q;
    assign wake_id       = id_q;

    // R4
    ack_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        wake_ack |-> (pwr_state == PM_RUN));

    // R6
    no_dma_wake_chk: assert property (@(posedge clk) disable iff (rst)
        wake_ack |-> (wake_id > IDW'(1)));

    // R3
    ack_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        wake_ack |-> $past(irq_en));

    // R10
    cfg_hold_lowpower_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != PM_RUN) |=> $stable(cfg_q));

    // R11
    stop_div8_chk: assert property (@(posedge clk) disable iff (rst)
        (in_run && state_d == PM_STOP && !cfg_q.sub_sel) |=> (cfg_div8 && $stable(cfg_ratio)));

    // R12
    refuse_stays_run_chk: assert property (@(posedge clk) disable iff (rst)
        (in_run && refused) |=> (pwr_state == PM_RUN && !wake_ack));

endmodule

// File: tb/pmw_wake_ctrl_tb.sv
`timescale 1ns/1ps
module pmw_wake_ctrl_tb;

    localparam int NS = 8;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wait_req = 0, stop_req = 0, periph_stop_wait = 0;
    logic cfg_we = 0, cfg_wr_sub = 0, cfg_wr_div8 = 0;
    logic [1:0] cfg_wr_ratio = 0;
    logic [NS-1:0] irq_req = 0, irq_qual = 0;
    logic [NS*PW-1:0] irq_prio = 0;
    logic [PW-1:0] cpu_ipl = 0;
    logic irq_en = 1;
    logic [1:0] pwr_state, cfg_ratio;
    logic clk_gate_en, periph_clk_en, cfg_sub, cfg_div8, wake_ack;
    logic [2:0] wake_id;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    pmw_wake_ctrl #(.NUM_SRC(NS), .PRIO_W(PW)) u_dut (
        .clk(clk), .rst(rst), .wait_req(wait_req), .stop_req(stop_req),
        .periph_stop_wait(periph_stop_wait), .cfg_we(cfg_we), .cfg_wr_sub(cfg_wr_sub),
        .cfg_wr_div8(cfg_wr_div8), .cfg_wr_ratio(cfg_wr_ratio), .irq_req(irq_req),
        .irq_prio(irq_prio), .irq_qual(irq_qual), .cpu_ipl(cpu_ipl), .irq_en(irq_en),
        .pwr_state(pwr_state), .clk_gate_en(clk_gate_en), .periph_clk_en(periph_clk_en),
        .cfg_sub(cfg_sub), .cfg_div8(cfg_div8), .cfg_ratio(cfg_ratio),
        .wake_ack(wake_ack), .wake_id(wake_id)
    );

    // {mode[1:0], src[2:0], prio[2:0], ipl[2:0], en, qual, expect_wake}
    // mode 0: wait with clocks, 1: wait without clocks, 2: stop
    localparam int NV = 16;
    localparam logic [13:0] VEC [NV] = '{
        {2'd0, 3'd6, 3'd3, 3'd1, 1'b1, 1'b0, 1'b1},  // R7
        {2'd2, 3'd7, 3'd1, 3'd0, 1'b1, 1'b0, 1'b1},  // R7
        {2'd0, 3'd0, 3'd7, 3'd0, 1'b1, 1'b1, 1'b0},  // R6
        {2'd2, 3'd1, 3'd7, 3'd0, 1'b1, 1'b1, 1'b0},  // R6
        {2'd0, 3'd2, 3'd4, 3'd0, 1'b1, 1'b1, 1'b1},  // R8
        {2'd0, 3'd2, 3'd4, 3'd0, 1'b1, 1'b0, 1'b0},  // R8
        {2'd1, 3'd2, 3'd4, 3'd0, 1'b1, 1'b1, 1'b0},  // R8
        {2'd2, 3'd2, 3'd4, 3'd0, 1'b1, 1'b1, 1'b0},  // R8
        {2'd0, 3'd3, 3'd2, 3'd0, 1'b1, 1'b0, 1'b1},  // R9
        {2'd1, 3'd4, 3'd2, 3'd0, 1'b1, 1'b0, 1'b0},  // R9
        {2'd1, 3'd5, 3'd2, 3'd0, 1'b1, 1'b1, 1'b1},  // R9
        {2'd2, 3'd3, 3'd2, 3'd0, 1'b1, 1'b1, 1'b1},  // R9
        {2'd2, 3'd5, 3'd2, 3'd0, 1'b1, 1'b0, 1'b0},  // R9
        {2'd0, 3'd6, 3'd2, 3'd2, 1'b1, 1'b0, 1'b0},  // R3 equal level
        {2'd0, 3'd6, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0},  // R3 priority zero
        {2'd2, 3'd7, 3'd5, 3'd1, 1'b0, 1'b0, 1'b0}   // R3 disabled
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_irq();
        irq_req = '0; irq_prio = '0; irq_qual = '0; cpu_ipl = '0; irq_en = 1'b1;
    endtask

    task automatic set_src(input int s, input int p, input logic q);
        irq_req[s] = 1'b1;
        irq_prio[s*PW +: PW] = PW'(p);
        irq_qual[s] = q;
    endtask

    task automatic write_cfg(input logic s, input logic d, input logic [1:0] r);
        cfg_we = 1; cfg_wr_sub = s; cfg_wr_div8 = d; cfg_wr_ratio = r;
        tick();
        cfg_we = 0;
        chk("R14 cfg write", {cfg_sub, cfg_div8, cfg_ratio}, {s, d, r});
    endtask

    task automatic enter(input int mode);
        periph_stop_wait = (mode == 1);
        if (mode == 2) stop_req = 1; else wait_req = 1;
        tick();
        stop_req = 0; wait_req = 0;
    endtask

    task automatic wake_by_pin();
        clear_irq();
        set_src(7, 7, 1'b0);
        tick();
        chk("R4 recover state", pwr_state, 0);
        clear_irq();
        tick();
    endtask

    initial begin
        clear_irq();
        tick(); tick();
        chk("R1 reset state", pwr_state, 0);
        rst = 0;
        tick();
        chk("R1 reset gate", {clk_gate_en, periph_clk_en, wake_ack}, 3'b110);
        chk("R1 reset cfg", {cfg_sub, cfg_div8, cfg_ratio}, 4'b0100);

        // Table walk over wake eligibility.
        for (int k = 0; k < NV; k++) begin
            logic [13:0] v;
            int md;
            v = VEC[k];
            md = int'(v[13:12]);
            clear_irq();
            enter(md);
            chk("R2 entry state", pwr_state, (md == 2) ? 2 : 1);
            chk("R2 gates", {clk_gate_en, periph_clk_en}, {1'b0, md == 0});
            set_src(int'(v[11:9]), int'(v[8:6]), v[1]);
            cpu_ipl = v[5:3];
            irq_en  = v[2];
            tick();
            if (v[0]) begin
                chk("R4 wake state", pwr_state, 0);
                chk("R4 wake ack", wake_ack, 1);
                chk("R4 wake id", wake_id, int'(v[11:9]));
                clear_irq();
                tick();
                chk("R4 ack single cycle", wake_ack, 0);
            end else begin
                chk("R6 R8 R9 R3 no wake state", pwr_state, (md == 2) ? 2 : 1);
                chk("R3 no wake ack", wake_ack, 0);
                wake_by_pin();
            end
        end

        // R2 stop wins over wait
        clear_irq();
        stop_req = 1; wait_req = 1;
        tick();
        stop_req = 0; wait_req = 0;
        chk("R2 stop priority", pwr_state, 2);
        // R5 highest priority wins
        set_src(6, 3, 1'b0); set_src(7, 5, 1'b0);
        tick();
        chk("R5 higher prio id", wake_id, 7);
        clear_irq(); tick();
        enter(2);
        set_src(6, 5, 1'b0); set_src(7, 5, 1'b0);
        tick();
        chk("R5 tie lowest index", wake_id, 6);
        clear_irq(); tick();

        // R11 stop from main clock
        write_cfg(1'b0, 1'b0, 2'b10);
        enter(2);
        chk("R11 main stop cfg", {cfg_sub, cfg_div8, cfg_ratio}, 4'b0110);
        wake_by_pin();
        chk("R10 cfg after stop", {cfg_sub, cfg_div8, cfg_ratio}, 4'b0110);

        // R10 wait keeps cfg; R14 writes ignored with request and in wait
        write_cfg(1'b0, 1'b0, 2'b01);
        cfg_we = 1; cfg_wr_sub = 1; cfg_wr_div8 = 1; cfg_wr_ratio = 2'b11;
        enter(0);
        chk("R14 write with request ignored", {cfg_sub, cfg_div8, cfg_ratio}, 4'b0001);
        tick();
        cfg_we = 0;
        chk("R14 write in wait ignored", {cfg_sub, cfg_div8, cfg_ratio}, 4'b0001);
        wake_by_pin();
        chk("R10 cfg after wait", {cfg_sub, cfg_div8, cfg_ratio}, 4'b0001);

        // R11 stop from subclock
        write_cfg(1'b1, 1'b0, 2'b11);
        enter(2);
        chk("R11 sub stop cfg", {cfg_sub, cfg_div8, cfg_ratio}, 4'b1011);
        wake_by_pin();

        // R12 refusal in low-speed operation
        enter(1);
        chk("R12 refused state", pwr_state, 0);
        chk("R12 refused ack", wake_ack, 0);
        chk("R12 refused cfg", {cfg_sub, cfg_div8, cfg_ratio}, 4'b1011);
        enter(0);
        chk("R12 wait with clocks allowed", pwr_state, 1);
        wake_by_pin();

        // R13 pending at request
        write_cfg(1'b0, 1'b0, 2'b00);
        set_src(6, 4, 1'b0);
        enter(2);
        chk("R13 stays run", pwr_state, 0);
        chk("R13 ack", wake_ack, 1);
        chk("R13 id", wake_id, 6);
        chk("R13 div8 not forced", cfg_div8, 0);
        clear_irq(); tick();

        // R1 reset from stop
        write_cfg(1'b0, 1'b0, 2'b11);
        enter(2);
        rst = 1;
        tick();
        rst = 0;
        chk("R1 reset from stop", pwr_state, 0);
        chk("R1 reset cfg again", {cfg_sub, cfg_div8, cfg_ratio}, 4'b0100);
        chk("R1 reset gate again", clk_gate_en, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=complete");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule